// File: doc/BRIEF.md
# Per-Thread Store Region Guard

This block sits between a multithreaded core's store path and its data memory. It decides, for every store, whether the issuing hardware thread may write the addressed location. Loads never pass through it, so every thread can still read all of memory. Memory is divided into 1 kB granules. A store is allowed when its granule lies in a shared area that starts at address 0, or inside a private window that belongs to the issuing thread.

The bounds are held in a small set of control registers. There is one inclusive upper granule index for the shared area, and an inclusive lower and upper granule index for each thread. Only a requester in supervisory mode can change them. A write from any other mode is dropped and reported as a privilege fault. Each store's verdict is registered. One cycle after the store is presented, the block raises either a memory write enable or a fault flag, and the store's thread and address appear beside it.

Top module: `wr_region_guard`

## Requirements
- R1: After reset, the shared area covers all of data memory and every private window is empty, so a store by any thread to any address, including the highest byte, is allowed.
- R2: Verdicts are registered. A store presented with `st_valid_i` high at a clock edge produces its verdict on the outputs during the following cycle. A cycle with `st_valid_i` low produces neither `wr_en_o` nor `fault_o` in the next cycle, and both are low out of reset.
- R3: The granule index of a store is the byte address shifted right by 10. A store is allowed when this index is less than or equal to the shared upper bound.
- R4: A store is also allowed when its granule index lies between the issuing thread's lower and upper bounds, both inclusive. A window whose lower bound exceeds its upper bound is empty.
- R5: A store that is not allowed keeps `wr_en_o` low and raises `fault_o` for one cycle. `wr_en_o` and `fault_o` are never high together, and `out_tid_o` and `out_addr_o` carry the thread and address of the store that was judged.
- R6: Bound registers are chosen by `cfg_sel_i`: 0 is the shared upper bound, 2t+1 is the lower bound of thread t, and 2t+2 is the upper bound of thread t. A select above 2*NUM_THREADS changes nothing.
- R7: A bound write with `cfg_super_i` low changes no bound and raises `priv_fault_o` in the next cycle. `priv_fault_o` is raised for no other reason.
- R8: A store presented in the same cycle as a bound write is judged with the bounds held before that write. The new bound applies from the next cycle on.
- R9: A thread's private window grants nothing to any other thread.
- R10: Bounds are inclusive at the byte level. The last byte of an upper-bound granule and the first byte of a lower-bound granule are allowed, and the bytes just outside them fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request present |
| st_tid_i | input | TID_W | Issuing thread of the store |
| st_addr_i | input | ADDR_W | Store byte address |
| cfg_we_i | input | 1 | Bound register write request |
| cfg_super_i | input | 1 | Requester is in supervisory mode |
| cfg_sel_i | input | SEL_W | Bound register select (R6 encoding) |
| cfg_val_i | input | IDX_W | New bound, as a granule index |
| wr_en_o | output | 1 | Memory write enable for the judged store |
| fault_o | output | 1 | Judged store was blocked |
| out_tid_o | output | TID_W | Thread of the judged store |
| out_addr_o | output | ADDR_W | Address of the judged store |
| priv_fault_o | output | 1 | Bound write refused for lack of privilege |

## Verification
The hardest case to reach from the ports is a store that arrives in the same cycle as the bound write that would change its verdict. The bench issues the store and a supervisory write in one driver step, and records the expected result from its shadow bounds before it applies that write. It also probes the granule edges of every window one byte inside and one byte outside. After a refused write, it re-issues a store the refused write would have allowed, which shows that the write had no effect.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  localparam int unsigned GRAN_LOG2 = 10;  // 1 kB granules
  localparam int unsigned SHARED_SEL = 0;

  function automatic int unsigned lo_sel(input int unsigned t);
    return 2 * t + 1;
  endfunction

  function automatic int unsigned hi_sel(input int unsigned t);
    return 2 * t + 2;
  endfunction
endpackage

// File: rtl/wrg_bound_regs.sv
module wrg_bound_regs #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned SEL_W       = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  cfg_we_i,
  input  logic                                  cfg_super_i,
  input  logic [SEL_W-1:0]                      cfg_sel_i,
  input  logic [IDX_W-1:0]                      cfg_val_i,
  output logic [IDX_W-1:0]                      shared_hi_o,
  output logic [NUM_THREADS-1:0][IDX_W-1:0]     win_lo_o,
  output logic [NUM_THREADS-1:0][IDX_W-1:0]     win_hi_o,
  output logic                                  priv_fault_o
);
  logic wr_ok;
  assign wr_ok = cfg_we_i & cfg_super_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                shared_hi_o <= '1;
    else if (wr_ok && cfg_sel_i == SEL_W'(wrg_pkg::SHARED_SEL)) shared_hi_o <= cfg_val_i;
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_win
    // empty window at reset: lower above upper
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                                 win_lo_o[t] <= '1;
      else if (wr_ok && cfg_sel_i == SEL_W'(wrg_pkg::lo_sel(t)))   win_lo_o[t] <= cfg_val_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                                 win_hi_o[t] <= '0;
      else if (wr_ok && cfg_sel_i == SEL_W'(wrg_pkg::hi_sel(t)))   win_hi_o[t] <= cfg_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) priv_fault_o <= 1'b0;
    else         priv_fault_o <= cfg_we_i & ~cfg_super_i;
  end
endmodule

// File: rtl/wrg_store_check.sv
module wrg_store_check #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned TID_W       = 2
) (
  input  logic [TID_W-1:0]                   st_tid_i,
  input  logic [ADDR_W-1:0]                  st_addr_i,
  input  logic [IDX_W-1:0]                   shared_hi_i,
  input  logic [NUM_THREADS-1:0][IDX_W-1:0]  win_lo_i,
  input  logic [NUM_THREADS-1:0][IDX_W-1:0]  win_hi_i,
  output logic                               allow_o
);
  logic [IDX_W-1:0]       idx;
  logic [NUM_THREADS-1:0] in_win;
  logic                   in_shared;
  logic                   in_own;

  assign idx       = st_addr_i[ADDR_W-1:wrg_pkg::GRAN_LOG2];
  assign in_shared = (idx <= shared_hi_i);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cmp
    assign in_win[t] = (idx >= win_lo_i[t]) && (idx <= win_hi_i[t]);
  end

  always_comb begin
    in_own = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (st_tid_i == TID_W'(t)) in_own = in_win[t];
  end

  assign allow_o = in_shared | in_own;
endmodule

// File: rtl/wr_region_guard.sv
module wr_region_guard #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ADDR_W      = 16,
  localparam int unsigned IDX_W      = ADDR_W - wrg_pkg::GRAN_LOG2,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned SEL_W      = $clog2(2 * NUM_THREADS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [TID_W-1:0]  st_tid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              cfg_we_i,
  input  logic              cfg_super_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [IDX_W-1:0]  cfg_val_i,
  output logic              wr_en_o,
  output logic              fault_o,
  output logic [TID_W-1:0]  out_tid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic              priv_fault_o
);
  logic [IDX_W-1:0]                  shared_hi;
  logic [NUM_THREADS-1:0][IDX_W-1:0] win_lo;
  logic [NUM_THREADS-1:0][IDX_W-1:0] win_hi;
  logic                              allow;

  wrg_bound_regs #(.NUM_THREADS(NUM_THREADS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_super_i  (cfg_super_i),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_val_i    (cfg_val_i),
    .shared_hi_o  (shared_hi),
    .win_lo_o     (win_lo),
    .win_hi_o     (win_hi),
    .priv_fault_o (priv_fault_o)
  );

  // judged against bounds held before any same-cycle write
  wrg_store_check #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TID_W(TID_W)) u_chk (
    .st_tid_i    (st_tid_i),
    .st_addr_i   (st_addr_i),
    .shared_hi_i (shared_hi),
    .win_lo_i    (win_lo),
    .win_hi_i    (win_hi),
    .allow_o     (allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o    <= 1'b0;
      fault_o    <= 1'b0;
      out_tid_o  <= '0;
      out_addr_o <= '0;
    end else begin
      wr_en_o <= st_valid_i & allow;
      fault_o <= st_valid_i & ~allow;
      if (st_valid_i) begin
        out_tid_o  <= st_tid_i;
        out_addr_o <= st_addr_i;
      end
    end
  end
endmodule

// File: rtl/wrg_checker.sv
module wrg_checker #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ADDR_W      = 16,
  localparam int unsigned IDX_W      = ADDR_W - wrg_pkg::GRAN_LOG2,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned SEL_W      = $clog2(2 * NUM_THREADS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_valid_i,
  input logic [TID_W-1:0]  st_tid_i,
  input logic [ADDR_W-1:0] st_addr_i,
  input logic              cfg_we_i,
  input logic              cfg_super_i,
  input logic [SEL_W-1:0]  cfg_sel_i,
  input logic [IDX_W-1:0]  cfg_val_i,
  input logic              wr_en_o,
  input logic              fault_o,
  input logic [TID_W-1:0]  out_tid_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic              priv_fault_o
);
  assert_we_fault_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && fault_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_valid_i |=> (!wr_en_o && !fault_o));

  assert_verdict_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |=> (wr_en_o || fault_o));

  assert_echo_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |=> (out_addr_o == $past(st_addr_i) && out_tid_o == $past(st_tid_i)));

  assert_priv_raise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_super_i) |=> priv_fault_o);

  assert_priv_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && !cfg_super_i) |=> !priv_fault_o);
endmodule

bind wr_region_guard wrg_checker #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W)) u_wrg_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .st_valid_i   (st_valid_i),
  .st_tid_i     (st_tid_i),
  .st_addr_i    (st_addr_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_super_i  (cfg_super_i),
  .cfg_sel_i    (cfg_sel_i),
  .cfg_val_i    (cfg_val_i),
  .wr_en_o      (wr_en_o),
  .fault_o      (fault_o),
  .out_tid_o    (out_tid_o),
  .out_addr_o   (out_addr_o),
  .priv_fault_o (priv_fault_o)
);

// File: tb/wr_region_guard_test.sv
`timescale 1ns/1ps
module wr_region_guard_test;
  localparam int unsigned N      = 4;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned IDX_W  = ADDR_W - 10;
  localparam int unsigned TID_W  = 2;
  localparam int unsigned SEL_W  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic              st_valid = 1'b0;
  logic [TID_W-1:0]  st_tid = '0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic              cfg_we = 1'b0;
  logic              cfg_super = 1'b0;
  logic [SEL_W-1:0]  cfg_sel = '0;
  logic [IDX_W-1:0]  cfg_val = '0;
  logic              wr_en, fault, priv_fault;
  logic [TID_W-1:0]  out_tid;
  logic [ADDR_W-1:0] out_addr;

  always #2.5 clk = ~clk;

  wr_region_guard #(.NUM_THREADS(N), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid), .st_tid_i(st_tid), .st_addr_i(st_addr),
    .cfg_we_i(cfg_we), .cfg_super_i(cfg_super), .cfg_sel_i(cfg_sel), .cfg_val_i(cfg_val),
    .wr_en_o(wr_en), .fault_o(fault), .out_tid_o(out_tid), .out_addr_o(out_addr),
    .priv_fault_o(priv_fault)
  );

  typedef struct {
    logic  we;
    logic  flt;
    logic  priv;
    int    tid;
    int    addr;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int sh_hi;
  int w_lo[N];
  int w_hi[N];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: one step per cycle, expectation from shadow bounds before update
  task automatic step(input bit sv, input int tid, input int addr,
                      input bit cw, input bit csup, input int csel, input int cval,
                      input string tag);
    exp_t e;
    int   idx;
    bit   ok;
    @(negedge clk);
    st_valid = sv; st_tid = TID_W'(tid); st_addr = ADDR_W'(addr);
    cfg_we = cw; cfg_super = csup; cfg_sel = SEL_W'(csel); cfg_val = IDX_W'(cval);
    idx = addr >> 10;
    ok  = (idx <= sh_hi) || (idx >= w_lo[tid] && idx <= w_hi[tid]);
    e.we = sv && ok; e.flt = sv && !ok; e.priv = cw && !csup;
    e.tid = tid; e.addr = addr; e.tag = tag;
    q.push_back(e);
    if (cw && csup) begin
      if (csel == 0) sh_hi = cval;
      else if (csel <= 2 * N) begin
        if (csel % 2 == 1) w_lo[(csel - 1) / 2] = cval;
        else               w_hi[(csel - 1) / 2] = cval;
      end
    end
  endtask

  task automatic st(input int tid, input int addr, input string tag);
    step(1, tid, addr, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input bit sup, input int sel, input int val, input string tag);
    step(0, 0, 0, 1, sup, sel, val, tag);
  endtask

  // monitor: pops the item pushed at the preceding negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(wr_en == e.we, e.tag, "wr_en", wr_en, e.we);
        chk(fault == e.flt, e.tag, "fault", fault, e.flt);
        chk(priv_fault == e.priv, e.tag, "priv_fault", priv_fault, e.priv);
        if (e.we || e.flt) begin
          chk(out_addr == ADDR_W'(e.addr), e.tag, "out_addr", out_addr, e.addr);
          chk(out_tid == TID_W'(e.tid), e.tag, "out_tid", out_tid, e.tid);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sh_hi = (1 << IDX_W) - 1;
    for (int t = 0; t < N; t++) begin w_lo[t] = (1 << IDX_W) - 1; w_hi[t] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state
    chk(!wr_en && !fault && !priv_fault, "R2", "reset outputs", {wr_en, fault, priv_fault}, 0);
    @(negedge clk) rst_ni = 1'b1;

    // R1: everything writable after reset
    st(0, 'hFFFF, "R1");
    st(3, 'h0000, "R1");
    st(2, 'h8123, "R1");
    step(0, 0, 0, 0, 0, 0, 0, "R2");

    // R8: shrink shared area while storing above it in the same cycle
    step(1, 1, 'h2000, 1, 1, 0, 3, "R8");
    st(1, 'h2000, "R8");
    // R3 / R10 shared edges
    st(1, 'h0FFF, "R10");
    st(1, 'h1000, "R10");
    st(0, 'h0000, "R3");
    st(2, 'h0C00, "R3");

    // R6 / R4: thread 1 window granules 8..9
    cfg(1, 3, 8, "R6");
    cfg(1, 4, 9, "R6");
    st(1, 'h2000, "R4");
    st(1, 'h27FF, "R10");
    st(1, 'h2800, "R10");
    st(1, 'h1FFF, "R10");
    // R9
    st(2, 'h2000, "R9");
    st(0, 'h2400, "R9");

    // R7: unprivileged attempt to open thread 2 over all memory
    cfg(0, 5, 0, "R7");
    cfg(0, 6, 63, "R7");
    cfg(0, 0, 63, "R7");
    st(2, 'h8000, "R7");
    st(1, 'h4000, "R7");

    // R6: selects above 2N ignored
    cfg(1, 9, 63, "R6");
    cfg(1, 15, 63, "R6");
    st(3, 'h1000, "R6");
    st(0, 'hFC00, "R6");
    // R6: thread 3 window at granule 20 via selects 7 and 8
    cfg(1, 7, 20, "R6");
    cfg(1, 8, 20, "R6");
    st(3, 'h5000, "R4");
    st(3, 'h53FF, "R10");
    st(3, 'h5400, "R10");
    st(3, 'h4FFF, "R10");
    // R4: empty window when lower > upper
    cfg(1, 3, 10, "R4");
    st(1, 'h2000, "R4");
    st(1, 'h2800, "R4");
    // R8: raise window in same cycle as store inside new range
    step(1, 1, 'h2800, 1, 1, 4, 10, "R8");
    st(1, 'h2800, "R8");
    // R7 privileged write with no store raises no fault
    cfg(1, 0, 0, "R7");
    st(2, 'h03FF, "R3");
    st(2, 'h0400, "R3");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R2");

    repeat (3) @(posedge clk);
    #1;
    chk(q.size() == 0, "R2", "queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule